// File: doc/BRIEF.md
# Display Field Completion Status Controller

This block keeps the completion status of a video display output. A programmed display mode decides which finished field sets which of three sticky status bits: one for field 1, one for field 2 and one for a whole frame. Whenever a status bit is set by a finished field, the block pulses a display-complete interrupt. In the continuous modes an enable input can mask that interrupt. In single-frame mode the interrupt is always raised.

Single-frame mode also expects software to acknowledge each frame. After field 2 sets the frame bit, software has until the end of the following vertical blanking interval to clear that bit. If the bit is still set when that blanking ends, the block pulses a not-acknowledged interrupt. Software clears each status bit with its own one-cycle strobe. Register decoding and video timing are handled outside the block.

Top module: `disp_fld_status`

## Requirements
- R1: During and directly after a synchronous active-high reset, all three status bits and both interrupt outputs are 0.
- R2: Mode code 3'b000 (single frame): a field-2 strobe sets the frame bit and pulses the display-complete interrupt whatever the enable says. A field-1 strobe sets no status bit.
- R3: Mode code 3'b001 (continuous field 1): a field-1 strobe sets the field-1 bit. A field-2 strobe sets no status bit.
- R4: Mode code 3'b010 (continuous field 2): a field-2 strobe sets the field-2 bit. A field-1 strobe sets no status bit.
- R5: Mode code 3'b011 (continuous frame): a field-2 strobe sets the frame bit. A field-1 strobe sets no status bit.
- R6: Mode code 3'b100 (continuous progressive): a field-1 strobe sets the frame bit and leaves the field-1 bit untouched.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 are reserved. In these modes, field strobes set no status bit and raise no interrupt.
- R8: In the continuous modes (001 to 100), a strobe that sets a status bit pulses the display-complete interrupt only when the enable input is 1 in the strobe cycle. The pulse lasts one cycle and appears in the cycle after the strobe.
- R9: A clear strobe resets its status bit at the next clock edge. If a set event and a clear for the same bit arrive in one cycle, the bit ends up set.
- R10: In single-frame mode, once a field-2 strobe has set the frame bit, the next vertical-blanking-end strobe pulses the not-acknowledged interrupt for one cycle, in the following cycle, when the frame bit is still set and is not being cleared in that same cycle. Only the first blanking end after the field-2 strobe is checked.
- R11: The not-acknowledged interrupt never fires in any mode other than single frame.
- R12: All status bits and interrupt outputs come straight from flip-flops, so every strobe takes effect at the outputs exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Display mode code |
| fld1_end | input | 1 | Field 1 display finished (one-cycle strobe) |
| fld2_end | input | 1 | Field 2 display finished (one-cycle strobe) |
| vblank_end | input | 1 | End of vertical blanking (one-cycle strobe) |
| clr_f1 | input | 1 | Software clear of the field-1 bit |
| clr_f2 | input | 1 | Software clear of the field-2 bit |
| clr_frm | input | 1 | Software clear of the frame bit |
| done_ie | input | 1 | Display-complete interrupt enable for the continuous modes |
| f1_done | output | 1 | Field-1 status bit |
| f2_done | output | 1 | Field-2 status bit |
| frm_done | output | 1 | Frame status bit |
| done_irq | output | 1 | Display-complete interrupt pulse |
| nack_irq | output | 1 | Not-acknowledged interrupt pulse |

## Verification
For each of the eight mode codes, the bench drives field-1 and field-2 strobes one at a time. The status bit that each strobe lands in tells the field-to-bit routing of every mode apart, including the progressive mode, which sends field 1 to the frame bit. Toggling the enable while strobes arrive separates single-frame mode, where the interrupt cannot be masked, from the continuous modes. Blanking-end strobes are sent with the frame bit left set, cleared early, cleared in the same cycle, and repeated a second time. These cases separate a missed acknowledge from a timely one and show that the check happens only once per frame. A long random run then mixes all inputs and compares every cycle against a bench model.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int MODE_W = 3;
  localparam int NSTAT  = 3;
  localparam int ST_F1  = 0;
  localparam int ST_F2  = 1;
  localparam int ST_FRM = 2;

  typedef enum logic [MODE_W-1:0] {
    DM_SINGLE = 3'd0,
    DM_CONT_F1 = 3'd1,
    DM_CONT_F2 = 3'd2,
    DM_CONT_FRM = 3'd3,
    DM_PROG = 3'd4,
    DM_RSV5 = 3'd5,
    DM_RSV6 = 3'd6,
    DM_RSV7 = 3'd7
  } dmode_e;
endpackage

// File: rtl/dfs_route.sv
module dfs_route
  import dfs_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              fld1_end,
  input  logic              fld2_end,
  output logic [NSTAT-1:0]  set_vec,
  output logic              is_single,
  output logic              irq_ungated
);
  dmode_e mode;

  always_comb begin
    mode        = dmode_e'(mode_sel);
    set_vec     = '0;
    is_single   = 1'b0;
    irq_ungated = 1'b0;
    unique case (mode)
      DM_SINGLE: begin
        set_vec[ST_FRM] = fld2_end;
        is_single       = 1'b1;
        irq_ungated     = 1'b1;
      end
      DM_CONT_F1:  set_vec[ST_F1]  = fld1_end;
      DM_CONT_F2:  set_vec[ST_F2]  = fld2_end;
      DM_CONT_FRM: set_vec[ST_FRM] = fld2_end;
      DM_PROG:     set_vec[ST_FRM] = fld1_end;
      default:     set_vec         = '0;
    endcase
  end
endmodule

// File: rtl/dfs_sticky.sv
module dfs_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/dfs_nack.sv
module dfs_nack (
  input  logic clk,
  input  logic rst,
  input  logic is_single,
  input  logic arm_i,
  input  logic vblank_end,
  input  logic frm_q,
  input  logic frm_clr,
  output logic nack_irq
);
  logic armed;
  logic fire;

  assign fire = armed & is_single & vblank_end & frm_q & ~frm_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      nack_irq <= 1'b0;
    end else begin
      nack_irq <= fire;
      if (arm_i && is_single)          armed <= 1'b1;
      else if (vblank_end || !is_single) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_fld_status.sv
module disp_fld_status
  import dfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              fld1_end,
  input  logic              fld2_end,
  input  logic              vblank_end,
  input  logic              clr_f1,
  input  logic              clr_f2,
  input  logic              clr_frm,
  input  logic              done_ie,
  output logic              f1_done,
  output logic              f2_done,
  output logic              frm_done,
  output logic              done_irq,
  output logic              nack_irq
);
  logic [NSTAT-1:0] set_vec;
  logic [NSTAT-1:0] clr_vec;
  logic [NSTAT-1:0] stat_q;
  logic             is_single;
  logic             irq_ungated;

  assign clr_vec[ST_F1]  = clr_f1;
  assign clr_vec[ST_F2]  = clr_f2;
  assign clr_vec[ST_FRM] = clr_frm;

  dfs_route u_route (
    .mode_sel    (mode_sel),
    .fld1_end    (fld1_end),
    .fld2_end    (fld2_end),
    .set_vec     (set_vec),
    .is_single   (is_single),
    .irq_ungated (irq_ungated)
  );

  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    dfs_sticky u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (stat_q[i])
    );
  end

  dfs_nack u_nack (
    .clk        (clk),
    .rst        (rst),
    .is_single  (is_single),
    .arm_i      (set_vec[ST_FRM]),
    .vblank_end (vblank_end),
    .frm_q      (stat_q[ST_FRM]),
    .frm_clr    (clr_frm),
    .nack_irq   (nack_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) done_irq <= 1'b0;
    else     done_irq <= (|set_vec) & (irq_ungated | done_ie);
  end

  assign f1_done  = stat_q[ST_F1];
  assign f2_done  = stat_q[ST_F2];
  assign frm_done = stat_q[ST_FRM];
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker
  import dfs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_sel,
  input logic              fld1_end,
  input logic              fld2_end,
  input logic              vblank_end,
  input logic              clr_frm,
  input logic              done_ie,
  input logic [NSTAT-1:0]  set_vec,
  input logic              frm_done,
  input logic              f1_done,
  input logic              done_irq,
  input logic              nack_irq
);
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!frm_done && !f1_done && !done_irq && !nack_irq));

  p_single_irq_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd0 && fld2_end) |=> (frm_done && done_irq));

  p_prog_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 3'd4 && fld1_end) |=> frm_done);

  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sel >= 3'd5) |=> !done_irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(fld1_end) || $past(fld2_end)));

  p_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 3'd0 && !done_ie) |=> !done_irq);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_vec[ST_FRM] |=> frm_done);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_frm && !set_vec[ST_FRM]) |=> !frm_done);

  p_nack_cause_r10: assert property (@(posedge clk) disable iff (rst)
    nack_irq |-> ($past(vblank_end) && $past(frm_done) && !$past(clr_frm)));

  p_nack_mode_r11: assert property (@(posedge clk) disable iff (rst)
    nack_irq |-> ($past(mode_sel) == 3'd0));
endmodule

bind disp_fld_status dfs_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_sel   (mode_sel),
  .fld1_end   (fld1_end),
  .fld2_end   (fld2_end),
  .vblank_end (vblank_end),
  .clr_frm    (clr_frm),
  .done_ie    (done_ie),
  .set_vec    (set_vec),
  .frm_done   (frm_done),
  .f1_done    (f1_done),
  .done_irq   (done_irq),
  .nack_irq   (nack_irq)
);

// File: tb/sim_disp_fld_status.sv
`timescale 1ns/1ps
module sim_disp_fld_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic fld1_end = 0, fld2_end = 0, vblank_end = 0;
  logic clr_f1 = 0, clr_f2 = 0, clr_frm = 0, done_ie = 0;
  logic f1_done, f2_done, frm_done, done_irq, nack_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  bit m_f1, m_f2, m_frm, m_armed, m_dirq, m_nirq;

  always #2.5 clk = ~clk;

  disp_fld_status u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .fld1_end(fld1_end), .fld2_end(fld2_end), .vblank_end(vblank_end),
    .clr_f1(clr_f1), .clr_f2(clr_f2), .clr_frm(clr_frm), .done_ie(done_ie),
    .f1_done(f1_done), .f2_done(f2_done), .frm_done(frm_done),
    .done_irq(done_irq), .nack_irq(nack_irq)
  );

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [4:0] pack_out();
    return {f1_done, f2_done, frm_done, done_irq, nack_irq};
  endfunction

  function automatic logic [4:0] pack_exp();
    return {m_f1, m_f2, m_frm, m_dirq, m_nirq};
  endfunction

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {f1,f2,frm,done_irq,nack_irq} actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  // Next-state model from the requirements
  task automatic model_step();
    bit sf1, sf2, sfr, fire;
    sf1  = (mode_sel == 3'd1) && fld1_end;
    sf2  = (mode_sel == 3'd2) && fld2_end;
    sfr  = ((mode_sel == 3'd0 || mode_sel == 3'd3) && fld2_end) || (mode_sel == 3'd4 && fld1_end);
    fire = m_armed && vblank_end && (mode_sel == 3'd0) && m_frm && !clr_frm;
    m_dirq = (sf1 | sf2 | sfr) && (mode_sel == 3'd0 || done_ie);
    m_nirq = fire;
    if (mode_sel == 3'd0 && sfr) m_armed = 1;
    else if (vblank_end || mode_sel != 3'd0) m_armed = 0;
    m_f1  = sf1 | (m_f1 & !clr_f1);
    m_f2  = sf2 | (m_f2 & !clr_f2);
    m_frm = sfr | (m_frm & !clr_frm);
  endtask

  // Inputs already driven (after a negedge); run one edge and compare (R12 timing)
  task automatic cycle(input string req);
    model_step();
    @(posedge clk);
    #1;
    check(pack_out(), pack_exp(), req);
    @(negedge clk);
    fld1_end = 0; fld2_end = 0; vblank_end = 0;
    clr_f1 = 0; clr_f2 = 0; clr_frm = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: outputs clean while in reset
    check(pack_out(), 5'b0, "R1");
    rst = 0;
    m_f1 = 0; m_f2 = 0; m_frm = 0; m_armed = 0; m_dirq = 0; m_nirq = 0;
    cycle("R1");

    // R2: single frame, field 1 sets nothing, field 2 sets frame + irq with ie=0
    mode_sel = 3'd0; done_ie = 0;
    fld1_end = 1; cycle("R2");
    check(pack_out(), 5'b00000, "R2");
    fld2_end = 1; cycle("R2");
    check(pack_out(), 5'b00110, "R2");
    // R10: blanking ends with frame still set -> nack next cycle
    vblank_end = 1; cycle("R10");
    check(pack_out(), 5'b00101, "R10");
    // R10: second blanking end is not checked again
    vblank_end = 1; cycle("R10");
    check(pack_out(), 5'b00100, "R10");
    // R10: clear in the same cycle as blanking end counts as in time
    fld2_end = 1; cycle("R10");
    vblank_end = 1; clr_frm = 1; cycle("R10");
    check(pack_out(), 5'b00000, "R10");
    // R9: set and clear together leave the bit set
    fld2_end = 1; clr_frm = 1; cycle("R9");
    check(pack_out(), 5'b00110, "R9");
    clr_frm = 1; cycle("R9");
    check(pack_out(), 5'b00000, "R9");

    // R8: continuous frame with interrupt disabled, then enabled
    mode_sel = 3'd3; done_ie = 0;
    fld2_end = 1; cycle("R8");
    check(pack_out(), 5'b00100, "R8");
    // R11: no nack in continuous frame mode even with frame bit set
    vblank_end = 1; cycle("R11");
    check(pack_out(), 5'b00100, "R11");
    done_ie = 1; clr_frm = 1; cycle("R5");
    fld2_end = 1; cycle("R8");
    check(pack_out(), 5'b00110, "R8");
    clr_frm = 1; cycle("R9");

    // R6: progressive sends field 1 to frame bit
    mode_sel = 3'd4;
    fld1_end = 1; cycle("R6");
    check(pack_out(), 5'b00110, "R6");
    clr_frm = 1; cycle("R6");

    // R3/R4
    mode_sel = 3'd1; fld2_end = 1; cycle("R3");
    fld1_end = 1; cycle("R3");
    check(pack_out(), 5'b10010, "R3");
    mode_sel = 3'd2; fld1_end = 1; cycle("R4");
    fld2_end = 1; cycle("R4");
    check(pack_out(), 5'b11010, "R4");
    clr_f1 = 1; clr_f2 = 1; cycle("R9");
    check(pack_out(), 5'b00000, "R9");

    // R7: reserved codes stay quiet
    for (int m = 5; m < 8; m++) begin
      mode_sel = 3'(m);
      fld1_end = 1; cycle("R7");
      fld2_end = 1; vblank_end = 1; cycle("R7");
      check(pack_out(), 5'b00000, "R7");
    end

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 40) == 0) mode_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 20) == 0) done_ie = 1'($urandom_range(0, 1));
      fld1_end   = ($urandom_range(0, 7) == 0);
      fld2_end   = ($urandom_range(0, 7) == 0);
      vblank_end = ($urandom_range(0, 6) == 0);
      clr_f1     = ($urandom_range(0, 9) == 0);
      clr_f2     = ($urandom_range(0, 9) == 0);
      clr_frm    = ($urandom_range(0, 9) == 0);
      cycle(mode_req(mode_sel));
    end

    // R1: reset mid-operation clears everything
    mode_sel = 3'd0; fld2_end = 1; cycle("R2");
    rst = 1;
    @(posedge clk); #1;
    check(pack_out(), 5'b0, "R1");
    @(negedge clk); rst = 0;
    m_f1 = 0; m_f2 = 0; m_frm = 0; m_armed = 0; m_dirq = 0; m_nirq = 0;
    vblank_end = 1; cycle("R10");
    check(pack_out(), 5'b0, "R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule